// File: doc/BRIEF.md
# DMA Channel Control and Status Register Bank

This block is the control and status register file of a multi-channel DMA controller that serves up to twelve channels. Software reaches it through a plain 32-bit register port. The port does a write when `wr_en` is high. Read data is combinational and always reflects the word that `addr` selects, so reading has no side effect.

Each channel has three control settings: a transfer mode, a direction bit and an interrupt enable. The block drives mode and direction straight to the channel engines. Each engine reports back a completion pulse, an error pulse and a live 2-bit activity state. Completion and error pulses set sticky flags. Software clears those flags by writing ones to them. The flags that are both set and enabled are merged into one interrupt line.

Channels 0 to 7 live in the low control word and the low status word. Channels 8 to 11 use the same field layout in a second control word and a second status word, with their fields numbered from channel 8.

Top module: `dma_regbank`

## Requirements
- R1: After reset, every control field, every enable and every flag is zero. Every word reads zero while all engine states are idle, `irq` is low, and `ch_mode` and `ch_dir` are zero.
- R2: Word 0x00 holds channels 0 to 7 in 4-bit slices starting at bit 4*c. Each slice has mode in bits [1:0] (0 off, 1 chained, 2 single, 3 stored as written) and direction in bit 2. Bit 3 of each slice reads 0. A write reaches `ch_mode`/`ch_dir` on the next clock edge, and the outputs hold their value while no write occurs.
- R3: Word 0x0C holds channels 8 to 11 with the same slice layout, slice index c-8. Bits 31:16 read 0.
- R4: The enable word at 0x08 holds channel c<8 at bit c and channel c>=8 at bit c+8. All other bits read 0.
- R5: Status word 0x10 shows, for channel c<8, the interrupt flag at bit c, the error flag at bit c+8 and the live engine state at bits [16+2c +: 2] (0 idle, 1 descriptor fetch, 2 wait, 3 bus access).
- R6: Status word 0x18 shows channel c>=8 with the interrupt flag at bit c-8, the error flag at bit c and the state at bits [16+2(c-8) +: 2].
- R7: A `ch_done` pulse sets the channel's interrupt flag. A `ch_err` pulse sets both its interrupt flag and its error flag. Both flags hold until cleared.
- R8: Writing a status word clears each flag whose bit is written 1. Flags written 0 and flags held in the other status word are unchanged.
- R9: When a set pulse and a clearing write hit the same flag in one cycle, the flag ends up set.
- R10: `irq` is high exactly when some channel has both its interrupt flag and its enable set. An error flag alone does not raise it.
- R11: Words 0x04 and 0x14 and every offset above 0x18 read zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address; bits [1:0] ignored |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| ch_done | input | NUM_CH | Per-channel completion pulse |
| ch_err | input | NUM_CH | Per-channel error pulse |
| ch_state | input | 2*NUM_CH | Per-channel engine state, 2 bits each |
| ch_mode | output | 2*NUM_CH | Per-channel mode, 2 bits each |
| ch_dir | output | NUM_CH | Per-channel direction |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach from the ports is a completion pulse and a clearing write that land on the same flag in the same cycle. The bench reaches it by driving `ch_done` and the status write in the same half-cycle slot before one rising edge. It then reads the flag back. The split of the high channels across two words is also tested: errors on channels 9 and 10 must leave the low status word untouched, and a blanket clear of the low word must leave them in place.

// File: rtl/dma_regbank_pkg.sv
package dma_regbank_pkg;
  localparam int MAX_CH   = 12;
  localparam int GRP_CH   = 8;
  localparam int SLICE_W  = 4;
  localparam int STATE_W  = 2;
  localparam int ERR_OFS  = 8;
  localparam int ST_OFS   = 16;

  // word indices (byte offset / 4)
  localparam int W_CTL_LO = 0;
  localparam int W_RSV_A  = 1;
  localparam int W_IEN    = 2;
  localparam int W_CTL_HI = 3;
  localparam int W_STS_LO = 4;
  localparam int W_RSV_B  = 5;
  localparam int W_STS_HI = 6;

  typedef enum logic [1:0] {
    MODE_OFF = 2'd0, MODE_CHAIN = 2'd1, MODE_SINGLE = 2'd2, MODE_RSVD = 2'd3
  } chan_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0, ST_FETCH = 2'd1, ST_WAIT = 2'd2, ST_BUS = 2'd3
  } eng_state_e;

  function automatic int ctl_word(input int ch);
    return (ch < GRP_CH) ? W_CTL_LO : W_CTL_HI;
  endfunction

  function automatic int sts_word(input int ch);
    return (ch < GRP_CH) ? W_STS_LO : W_STS_HI;
  endfunction

  function automatic int ien_bit(input int ch);
    return (ch < GRP_CH) ? ch : ch + GRP_CH;
  endfunction

  function automatic int grp_idx(input int ch);
    return ch % GRP_CH;
  endfunction
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regbank_pkg::*;
#(
  parameter int CH   = 0,
  parameter int WIDX = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [WIDX-1:0] wr_word,
  input  logic [31:0]     wdata,
  input  logic            set_done,
  input  logic            set_err,
  output logic [1:0]      mode_o,
  output logic            dir_o,
  output logic            ien_o,
  output logic            irq_flag_o,
  output logic            err_flag_o
);
  localparam int LC = grp_idx(CH);
  localparam int CW = ctl_word(CH);
  localparam int SW = sts_word(CH);
  localparam int IB = ien_bit(CH);

  logic ctl_hit, ien_hit, sts_hit;
  logic clr_irq, clr_err;
  logic unused_wd;

  assign ctl_hit = wr_en && (wr_word == WIDX'(CW));
  assign ien_hit = wr_en && (wr_word == WIDX'(W_IEN));
  assign sts_hit = wr_en && (wr_word == WIDX'(SW));
  assign clr_irq = sts_hit && wdata[LC];
  assign clr_err = sts_hit && wdata[LC+ERR_OFS];
  assign unused_wd = ^wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_o     <= MODE_OFF;
      dir_o      <= 1'b0;
      ien_o      <= 1'b0;
      irq_flag_o <= 1'b0;
      err_flag_o <= 1'b0;
    end else begin
      if (ctl_hit) begin
        mode_o <= wdata[SLICE_W*LC +: 2];
        dir_o  <= wdata[SLICE_W*LC + 2];
      end
      if (ien_hit) ien_o <= wdata[IB];
      // set has priority over a same-cycle clear
      irq_flag_o <= (irq_flag_o && !clr_irq) || set_done || set_err;
      err_flag_o <= (err_flag_o && !clr_err) || set_err;
    end
  end
endmodule

// File: rtl/dma_rd_mux.sv
module dma_rd_mux
  import dma_regbank_pkg::*;
#(
  parameter int NUM_CH = 12,
  parameter int WIDX   = 3
) (
  input  logic [WIDX-1:0]         rd_word,
  input  logic [2*NUM_CH-1:0]     mode,
  input  logic [NUM_CH-1:0]       dir,
  input  logic [NUM_CH-1:0]       ien,
  input  logic [NUM_CH-1:0]       irq_flag,
  input  logic [NUM_CH-1:0]       err_flag,
  input  logic [STATE_W*NUM_CH-1:0] state,
  output logic [31:0]             rdata
);
  always_comb begin
    rdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (rd_word == WIDX'(ctl_word(c))) begin
        rdata[SLICE_W*grp_idx(c) +: 2] = mode[2*c +: 2];
        rdata[SLICE_W*grp_idx(c) + 2]  = dir[c];
      end
      if (rd_word == WIDX'(W_IEN))
        rdata[ien_bit(c)] = ien[c];
      if (rd_word == WIDX'(sts_word(c))) begin
        rdata[grp_idx(c)]                              = irq_flag[c];
        rdata[grp_idx(c) + ERR_OFS]                    = err_flag[c];
        rdata[ST_OFS + STATE_W*grp_idx(c) +: STATE_W]  = state[STATE_W*c +: STATE_W];
      end
    end
  end
endmodule

// File: rtl/dma_regbank.sv
module dma_regbank
  import dma_regbank_pkg::*;
#(
  parameter int NUM_CH = 12,
  parameter int ADDR_W = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [31:0]           wdata,
  output logic [31:0]           rdata,
  input  logic [NUM_CH-1:0]     ch_done,
  input  logic [NUM_CH-1:0]     ch_err,
  input  logic [2*NUM_CH-1:0]   ch_state,
  output logic [2*NUM_CH-1:0]   ch_mode,
  output logic [NUM_CH-1:0]     ch_dir,
  output logic                  irq
);
  localparam int WIDX = ADDR_W - 2;

  logic [WIDX-1:0]   word;
  logic [NUM_CH-1:0] ien_vec;
  logic [NUM_CH-1:0] irq_flag;
  logic [NUM_CH-1:0] err_flag;
  logic              unused_lsb;

  assign word       = addr[ADDR_W-1:2];
  assign unused_lsb = ^addr[1:0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dma_chan_regs #(.CH(c), .WIDX(WIDX)) u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_word    (word),
      .wdata      (wdata),
      .set_done   (ch_done[c]),
      .set_err    (ch_err[c]),
      .mode_o     (ch_mode[2*c +: 2]),
      .dir_o      (ch_dir[c]),
      .ien_o      (ien_vec[c]),
      .irq_flag_o (irq_flag[c]),
      .err_flag_o (err_flag[c])
    );
  end

  dma_rd_mux #(.NUM_CH(NUM_CH), .WIDX(WIDX)) u_rd (
    .rd_word  (word),
    .mode     (ch_mode),
    .dir      (ch_dir),
    .ien      (ien_vec),
    .irq_flag (irq_flag),
    .err_flag (err_flag),
    .state    (ch_state),
    .rdata    (rdata)
  );

  assign irq = |(irq_flag & ien_vec);
endmodule

// File: rtl/dma_regbank_chk.sv
module dma_regbank_chk #(
  parameter int NUM_CH = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [NUM_CH-1:0]   ch_done,
  input logic [NUM_CH-1:0]   ch_err,
  input logic [2*NUM_CH-1:0] ch_mode,
  input logic [NUM_CH-1:0]   ch_dir,
  input logic                irq,
  input logic [NUM_CH-1:0]   irq_flag,
  input logic [NUM_CH-1:0]   err_flag,
  input logic [NUM_CH-1:0]   ien_vec
);
  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(ch_mode) && $stable(ch_dir))); // R2

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_vec == '0) |-> !irq); // R10

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_done[c] || ch_err[c]) |=> irq_flag[c]); // R9

    AST_ERR_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      ch_err[c] |=> err_flag[c]); // R7

    AST_CLEAR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_flag[c]) |-> $past(wr_en)); // R8
  end
endmodule

bind dma_regbank dma_regbank_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .ch_done  (ch_done),
  .ch_err   (ch_err),
  .ch_mode  (ch_mode),
  .ch_dir   (ch_dir),
  .irq      (irq),
  .irq_flag (irq_flag),
  .err_flag (err_flag),
  .ien_vec  (ien_vec)
);

// File: tb/dma_regbank_tb_top.sv
module dma_regbank_tb_top;
  localparam int NCH = 12;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_en = 1'b0;
  logic [4:0]      addr = '0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic [NCH-1:0]  ch_done = '0;
  logic [NCH-1:0]  ch_err = '0;
  logic [2*NCH-1:0] ch_state = '0;
  logic [2*NCH-1:0] ch_mode;
  logic [NCH-1:0]  ch_dir;
  logic            irq;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  dma_regbank #(.NUM_CH(NCH), .ADDR_W(5)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ch_done(ch_done), .ch_err(ch_err), .ch_state(ch_state),
    .ch_mode(ch_mode), .ch_dir(ch_dir), .irq(irq)
  );

  typedef struct packed {
    logic [4:0]  a;
    logic [31:0] d;
    logic [31:0] e;
    logic [3:0]  r;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{5'h00, 32'hFFFF_FFFF, 32'h7777_7777, 4'd2},  // R2
    '{5'h00, 32'h1234_5678, 32'h1234_5670, 4'd2},  // R2
    '{5'h0C, 32'hFFFF_FFFF, 32'h0000_7777, 4'd3},  // R3
    '{5'h0C, 32'h0000_5A21, 32'h0000_5221, 4'd3},  // R3
    '{5'h08, 32'hFFFF_FFFF, 32'h000F_00FF, 4'd4},  // R4
    '{5'h08, 32'h0005_0081, 32'h0005_0081, 4'd4},  // R4
    '{5'h04, 32'hFFFF_FFFF, 32'h0000_0000, 4'd11}, // R11
    '{5'h14, 32'hFFFF_FFFF, 32'h0000_0000, 4'd11}, // R11
    '{5'h1C, 32'hFFFF_FFFF, 32'h0000_0000, 4'd11}  // R11
  };

  function automatic string rname(input logic [3:0] r);
    case (r)
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string req);
    addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  task automatic pulse(input logic [NCH-1:0] dn, input logic [NCH-1:0] er);
    @(negedge clk);
    ch_done = dn; ch_err = er;
    @(negedge clk);
    ch_done = '0; ch_err = '0;
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int w = 0; w < 8; w++) rd_chk(5'(w * 4), 32'h0, "R1");
    check("R1", {31'h0, irq}, 32'h0);
    check("R1", {8'h0, ch_mode}, 32'h0);
    check("R1", {20'h0, ch_dir}, 32'h0);

    // table: write, then read back
    for (int i = 0; i < 9; i++) begin
      wr(VECS[i].a, VECS[i].d);
      rd_chk(VECS[i].a, VECS[i].e, rname(VECS[i].r));
    end

    // R11 ignored writes left control untouched
    rd_chk(5'h00, 32'h1234_5670, "R11");
    rd_chk(5'h0C, 32'h0000_5221, "R11");
    rd_chk(5'h08, 32'h0005_0081, "R11");

    // R2/R3 outputs to engines
    check("R2", {30'h0, ch_mode[3:2]}, 32'd3);
    check("R2", {31'h0, ch_dir[1]}, 32'd1);
    check("R2", {30'h0, ch_mode[5:4]}, 32'd2);
    check("R2", {30'h0, ch_mode[1:0]}, 32'd0);
    check("R3", {30'h0, ch_mode[17:16]}, 32'd1);
    check("R3", {30'h0, ch_mode[23:22]}, 32'd1);
    check("R3", {31'h0, ch_dir[11]}, 32'd1);
    check("R3", {31'h0, ch_dir[8]}, 32'd0);

    // R5/R6 live state fields
    @(negedge clk);
    ch_state = 24'hE4_1BC6;
    rd_chk(5'h10, 32'h1BC6_0000, "R5");
    rd_chk(5'h18, 32'h00E4_0000, "R6");
    ch_state = '0;

    // enables: ch0, ch7, ch8, ch10
    pulse(12'h008, 12'h000);
    rd_chk(5'h10, 32'h0000_0008, "R7");
    check("R10", {31'h0, irq}, 32'd0);
    pulse(12'h001, 12'h000);
    rd_chk(5'h10, 32'h0000_0009, "R7");
    check("R10", {31'h0, irq}, 32'd1);
    wr(5'h10, 32'h0000_0001);
    rd_chk(5'h10, 32'h0000_0008, "R8");
    check("R8", {31'h0, irq}, 32'd0);
    wr(5'h10, 32'h0000_0000);
    rd_chk(5'h10, 32'h0000_0008, "R8");
    pulse(12'h000, 12'h200);
    rd_chk(5'h18, 32'h0000_0202, "R6");
    rd_chk(5'h10, 32'h0000_0008, "R6");
    check("R10", {31'h0, irq}, 32'd0);
    wr(5'h10, 32'hFFFF_FFFF);
    rd_chk(5'h10, 32'h0000_0000, "R8");
    rd_chk(5'h18, 32'h0000_0202, "R8");
    pulse(12'h000, 12'h400);
    rd_chk(5'h18, 32'h0000_0606, "R7");
    check("R10", {31'h0, irq}, 32'd1);
    wr(5'h18, 32'h0000_0004);
    rd_chk(5'h18, 32'h0000_0602, "R8");
    check("R10", {31'h0, irq}, 32'd0);

    // R9 set beats same-cycle clear
    @(negedge clk);
    ch_done = 12'h020; wr_en = 1'b1; addr = 5'h10; wdata = 32'h0000_0020;
    @(negedge clk);
    ch_done = '0; wr_en = 1'b0;
    rd_chk(5'h10, 32'h0000_0020, "R9");
    check("R10", {31'h0, irq}, 32'd0);

    // R10 enabling a pending flag raises irq
    wr(5'h08, 32'h0005_00A1);
    check("R10", {31'h0, irq}, 32'd1);

    // R7 flags persist
    repeat (5) @(negedge clk);
    rd_chk(5'h10, 32'h0000_0020, "R7");
    pulse(12'h000, 12'h004);
    rd_chk(5'h10, 32'h0000_0424, "R7");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule